// File: doc/BRIEF.md
# Legacy keyboard port trap controller

This block snoops I/O cycles aimed at the two legacy keyboard controller ports, the data port at 0x60 and the command/status port at 0x64. It does this for a configurable number of host controllers (three by default). Each controller sees its own 16-bit control register view. The four port trap flags and the end-of-pass-through flag are each one logical bit held once and shown in every view. A write-one-to-clear through any view clears such a flag for all of them. The USB interrupt flag and the enable bits belong to one controller only. Each controller has its own SMI request line, driven from its view's flags and enables.

A small sequencer recognises the A20 gate pass-through sequence. That sequence is a command byte 0xD1 written to 0x64, then any data byte written to 0x60, then 0xFF written to 0x64. While the sequencer is enabled, the accesses that form the sequence raise no trap flag. The sequencer is enabled when any controller sets its pass-through enable bit. The sequencer has three states: IDLE, GOT_CMD (the enter command has been seen) and GOT_DATA (the data byte has been seen). On each keyboard port access it takes exactly one named transition:
- ENTER: IDLE to GOT_CMD, on 0xD1 written to 0x64.
- DATA: GOT_CMD to GOT_DATA, on any write to 0x60.
- EXIT: GOT_DATA to IDLE, on 0xFF written to 0x64. This transition raises the end-of-pass-through flag.
- RESTART: GOT_CMD or GOT_DATA to GOT_CMD, on 0xD1 written to 0x64.
- ABORT: any other keyboard access, which returns the sequencer to IDLE. That access traps normally.
- NONE: taken when there is no keyboard access, or when the sequencer is disabled. A disabled sequencer is held in IDLE.

Top module: `kbd_port_trap`

## Requirements
- R1: After reset every bit of every controller view reads 0 and every SMI line is low.
- R2: A snoop strobe to 0x60 or 0x64 that the sequencer does not consume sets one shared trap flag. The mapping is: bit 8 for a read of 0x60, bit 9 for a write of 0x60, bit 10 for a read of 0x64 and bit 11 for a write of 0x64. The flag becomes visible in all views on the cycle after the strobe. A strobe to any other address changes nothing.
- R3: Writing a one to bit 8, 9, 10, 11 or 15 through any view clears that shared flag in all views. Writing a zero there leaves the flag unchanged. If a set and a clear of the same flag occur in the same cycle, the flag ends up set.
- R4: Bit 12 is a per-controller USB interrupt flag. It is set by that controller's usb_evt line and cleared only by a write of one to bit 12 through that controller's own view.
- R5: Bits 0-5, 7 and 13 are independent read/write bits in each view: trap enables at bits 0-3, USB SMI enable at bit 4, pass-through enable at bit 5, end-of-pass-through SMI enable at bit 7 and PCI interrupt enable at bit 13. Bit 14 always reads 0 and ignores writes. Bit 6 is read-only.
- R6: smi_o[c] is high when any of the following holds:
  - trap flag 8+i is set and view c's enable bit i is set, for any i from 0 to 3;
  - view c's bit 12 and bit 4 are both set;
  - bit 15 is set and bit 7 is set in at least one view.
- R7: With bit 5 set in at least one view, the sequence 0xD1 written to 0x64, a write to 0x60 and 0xFF written to 0x64 is recognised. Bit 6 reads 1 in all views from the cycle after the first step until the cycle after the last step. Completing the sequence sets bit 15.
- R8: Accesses that form or restart the sequence set none of bits 8-11. Any other keyboard access aborts the sequence, so bit 6 reads 0 afterwards, and that access sets its trap flag. A 0xD1 write to 0x64 during the sequence restarts it.
- R9: When bit 5 is cleared in every view, bit 6 reads 0 by the second clock edge after that write. While the sequencer is disabled, sequence bytes trap like any other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_vld | input | 1 | Single-cycle I/O snoop strobe |
| snp_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| snp_addr | input | 16 | I/O port address of the snooped cycle |
| snp_data | input | 8 | Write data of the snooped cycle |
| usb_evt | input | NCTRL | Per-controller USB interrupt event pulse |
| reg_we | input | NCTRL | Per-controller register write strobe |
| reg_wdata | input | 16*NCTRL | Per-controller write data, controller c at bits [16c+15:16c] |
| reg_rdata | output | 16*NCTRL | Per-controller register view, same packing |
| smi_o | output | NCTRL | Per-controller SMI request |

## Verification
The following rules are checked by assertions on every cycle:
- a set wins over a clear on a shared flag, and a clear alone empties it;
- a sequence-forming access raises no trap flag;
- the sequencer lands in IDLE after EXIT and whenever it is disabled;
- a USB event raises bit 12;
- an active SMI line always has a flag behind it.

Other behaviour can only be shown by the bench scenarios. These cover the mapping of the four access kinds onto bits 8-11 and the aliasing of flags across views. They also include a sweep of every trap-flag pattern against every enable nibble in each controller. Further scenarios cover the ORing of bit 7 across views, and the abort, restart and disable orderings of the sequencer.

// File: rtl/kbt_pkg.sv
package kbt_pkg;
    localparam int REG_W      = 16;
    localparam int N_TRAP     = 4;
    localparam int B_USB_EN   = 4;
    localparam int B_PT_EN    = 5;
    localparam int B_PT_ST    = 6;
    localparam int B_PTEND_EN = 7;
    localparam int B_TRAP0    = 8;
    localparam int B_USB_ST   = 12;
    localparam int B_PCI_EN   = 13;
    localparam int B_PTEND_ST = 15;
    localparam logic [REG_W-1:0] RW_MASK = 16'h20BF;
    localparam logic [7:0] CMD_ENTER = 8'hD1;
    localparam logic [7:0] CMD_EXIT  = 8'hFF;

    // access kind index: 0 read data port, 1 write data port,
    // 2 read command port, 3 write command port
    localparam int A_RD_DAT = 0;
    localparam int A_WR_DAT = 1;
    localparam int A_RD_CMD = 2;
    localparam int A_WR_CMD = 3;

    typedef enum logic [1:0] {
        PT_IDLE     = 2'd0,
        PT_GOT_CMD  = 2'd1,
        PT_GOT_DATA = 2'd2
    } pt_state_e;

    typedef enum logic [2:0] {
        TR_NONE    = 3'd0,
        TR_ENTER   = 3'd1,
        TR_DATA    = 3'd2,
        TR_EXIT    = 3'd3,
        TR_RESTART = 3'd4,
        TR_ABORT   = 3'd5
    } pt_trans_e;
endpackage

// File: rtl/kbt_passthru.sv
module kbt_passthru
    import kbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pt_en,
    input  logic [N_TRAP-1:0] acc,
    input  logic [7:0]        wdata,
    output logic              consume,
    output logic              done,
    output logic              active
);
    pt_state_e state_q, state_d;
    pt_trans_e trans;

    logic enter_byte, exit_byte;
    assign enter_byte = acc[A_WR_CMD] && (wdata == CMD_ENTER);
    assign exit_byte  = acc[A_WR_CMD] && (wdata == CMD_EXIT);

    // transition selection
    always_comb begin
        trans = TR_NONE;
        if (pt_en && (acc != '0)) begin
            unique case (state_q)
                PT_IDLE: begin
                    if (enter_byte) trans = TR_ENTER;
                    else            trans = TR_ABORT;
                end
                PT_GOT_CMD: begin
                    if (acc[A_WR_DAT])   trans = TR_DATA;
                    else if (enter_byte) trans = TR_RESTART;
                    else                 trans = TR_ABORT;
                end
                PT_GOT_DATA: begin
                    if (exit_byte)       trans = TR_EXIT;
                    else if (enter_byte) trans = TR_RESTART;
                    else                 trans = TR_ABORT;
                end
                default: trans = TR_ABORT;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        if (!pt_en) begin
            state_d = PT_IDLE;
        end else begin
            unique case (trans)
                TR_ENTER, TR_RESTART: state_d = PT_GOT_CMD;
                TR_DATA:              state_d = PT_GOT_DATA;
                TR_EXIT, TR_ABORT:    state_d = PT_IDLE;
                default:              state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PT_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        consume = 1'b0;
        done    = 1'b0;
        unique case (trans)
            TR_ENTER, TR_DATA, TR_RESTART: consume = 1'b1;
            TR_EXIT: begin
                consume = 1'b1;
                done    = 1'b1;
            end
            default: ;
        endcase
        active = (state_q != PT_IDLE);
    end

    // R7
    pt_exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == PT_IDLE));
    // R9
    pt_disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_en |=> !active);
    // R8
    pt_consume_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (pt_en && acc != '0));
endmodule

// File: rtl/kbt_shared_status.sv
module kbt_shared_status
    import kbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRAP-1:0] set_trap,
    input  logic [N_TRAP-1:0] clr_trap,
    input  logic              set_ptend,
    input  logic              clr_ptend,
    output logic [N_TRAP-1:0] trap_q,
    output logic              ptend_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q  <= '0;
            ptend_q <= 1'b0;
        end else begin
            trap_q  <= (trap_q & ~clr_trap) | set_trap;
            ptend_q <= (ptend_q & ~clr_ptend) | set_ptend;
        end
    end

    for (genvar i = 0; i < N_TRAP; i++) begin : g_chk
        // R3
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_trap[i] |=> trap_q[i]);
        // R3
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_trap[i] && !set_trap[i]) |=> !trap_q[i]);
    end
    // R3
    ptend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ptend && !set_ptend) |=> !ptend_q);
endmodule

// File: rtl/kbt_ctrl_reg.sv
module kbt_ctrl_reg
    import kbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              usb_evt,
    input  logic [N_TRAP-1:0] trap_q,
    input  logic              ptend_q,
    input  logic              pt_active,
    input  logic              ptend_en_any,
    output logic [REG_W-1:0]  rdata,
    output logic              pt_en,
    output logic              ptend_en,
    output logic              smi_o
);
    logic [REG_W-1:0] rw_q;
    logic             usb_st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q     <= '0;
            usb_st_q <= 1'b0;
        end else begin
            if (we) rw_q <= wdata & RW_MASK;
            usb_st_q <= (usb_st_q & ~(we & wdata[B_USB_ST])) | usb_evt;
        end
    end

    always_comb begin
        rdata                            = rw_q;
        rdata[B_PT_ST]                   = pt_active;
        rdata[B_TRAP0 +: N_TRAP]         = trap_q;
        rdata[B_USB_ST]                  = usb_st_q;
        rdata[B_PTEND_ST]                = ptend_q;
        pt_en    = rw_q[B_PT_EN];
        ptend_en = rw_q[B_PTEND_EN];
        smi_o    = (|(trap_q & rw_q[N_TRAP-1:0]))
                 | (usb_st_q & rw_q[B_USB_EN])
                 | (ptend_q & ptend_en_any);
    end

    // R6
    smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> (rdata[B_PTEND_ST] || rdata[B_USB_ST:B_TRAP0] != '0));
    // R4
    usb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_evt |=> rdata[B_USB_ST]);
endmodule

// File: rtl/kbd_port_trap.sv
module kbd_port_trap
    import kbt_pkg::*;
#(
    parameter int NCTRL     = 3,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snp_vld,
    input  logic                   snp_wr,
    input  logic [ADDR_W-1:0]      snp_addr,
    input  logic [7:0]             snp_data,
    input  logic [NCTRL-1:0]       usb_evt,
    input  logic [NCTRL-1:0]       reg_we,
    input  logic [NCTRL*REG_W-1:0] reg_wdata,
    output logic [NCTRL*REG_W-1:0] reg_rdata,
    output logic [NCTRL-1:0]       smi_o
);
    logic              hit_dat, hit_cmd;
    logic [N_TRAP-1:0] acc;
    logic              consume, done, pt_active;
    logic [N_TRAP-1:0] trap_q, clr_trap;
    logic              ptend_q, clr_ptend;
    logic [NCTRL-1:0]  pt_en_c, ptend_en_c;

    assign hit_dat = snp_vld && (snp_addr == DATA_PORT);
    assign hit_cmd = snp_vld && (snp_addr == CMD_PORT);
    assign acc[A_RD_DAT] = hit_dat && !snp_wr;
    assign acc[A_WR_DAT] = hit_dat &&  snp_wr;
    assign acc[A_RD_CMD] = hit_cmd && !snp_wr;
    assign acc[A_WR_CMD] = hit_cmd &&  snp_wr;

    always_comb begin
        clr_trap  = '0;
        clr_ptend = 1'b0;
        for (int c = 0; c < NCTRL; c++) begin
            if (reg_we[c]) begin
                clr_trap  = clr_trap | reg_wdata[c*REG_W+B_TRAP0 +: N_TRAP];
                clr_ptend = clr_ptend | reg_wdata[c*REG_W+B_PTEND_ST];
            end
        end
    end

    kbt_passthru u_pt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pt_en   (|pt_en_c),
        .acc     (acc),
        .wdata   (snp_data),
        .consume (consume),
        .done    (done),
        .active  (pt_active)
    );

    kbt_shared_status u_shared (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_trap  (acc & {N_TRAP{!consume}}),
        .clr_trap  (clr_trap),
        .set_ptend (done),
        .clr_ptend (clr_ptend),
        .trap_q    (trap_q),
        .ptend_q   (ptend_q)
    );

    for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
        kbt_ctrl_reg u_reg (
            .clk          (clk),
            .rst_n        (rst_n),
            .we           (reg_we[c]),
            .wdata        (reg_wdata[c*REG_W +: REG_W]),
            .usb_evt      (usb_evt[c]),
            .trap_q       (trap_q),
            .ptend_q      (ptend_q),
            .pt_active    (pt_active),
            .ptend_en_any (|ptend_en_c),
            .rdata        (reg_rdata[c*REG_W +: REG_W]),
            .pt_en        (pt_en_c[c]),
            .ptend_en     (ptend_en_c[c]),
            .smi_o        (smi_o[c])
        );
    end

    // R8
    seq_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && trap_q == '0) |=> (trap_q == '0));
    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_dat && !hit_cmd && clr_trap == '0) |=> $stable(trap_q));
endmodule

// File: tb/test_kbd_port_trap.sv
module test_kbd_port_trap;
    localparam int NC = 3;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            snp_vld = 1'b0, snp_wr = 1'b0;
    logic [15:0]     snp_addr = '0;
    logic [7:0]      snp_data = '0;
    logic [NC-1:0]   usb_evt = '0, reg_we = '0;
    logic [NC*W-1:0] reg_wdata = '0;
    logic [NC*W-1:0] reg_rdata;
    logic [NC-1:0]   smi_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    kbd_port_trap i_kbd_port_trap (
        .clk(clk), .rst_n(rst_n), .snp_vld(snp_vld), .snp_wr(snp_wr),
        .snp_addr(snp_addr), .snp_data(snp_data), .usb_evt(usb_evt),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smi_o(smi_o)
    );

    function automatic logic [15:0] view(int c);
        return reg_rdata[c*W +: W];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag, logic [15:0] mask, logic [15:0] exp);
        for (int c = 0; c < NC; c++) chk(tag, view(c) & mask, exp & mask);
    endtask

    task automatic kbd(bit is_cmd, bit wr, logic [7:0] d, logic [15:0] a = 16'h0);
        @(negedge clk);
        snp_vld = 1'b1; snp_wr = wr; snp_data = d;
        snp_addr = (a != 0) ? a : (is_cmd ? 16'h0064 : 16'h0060);
        @(negedge clk);
        snp_vld = 1'b0; snp_wr = 1'b0; snp_data = '0; snp_addr = '0;
    endtask

    task automatic wr_reg(int c, logic [15:0] d);
        @(negedge clk);
        reg_we[c] = 1'b1; reg_wdata[c*W +: W] = d;
        @(negedge clk);
        reg_we = '0; reg_wdata = '0;
    endtask

    task automatic set_traps(logic [3:0] s);
        if (s[0]) kbd(0, 0, 8'h00);
        if (s[1]) kbd(0, 1, 8'h00);
        if (s[2]) kbd(1, 0, 8'h00);
        if (s[3]) kbd(1, 1, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1 view", 16'hFFFF, 16'h0000);
        chk("R1 smi", smi_o, 0);

        // R2 each access kind maps to its bit, R3 clear from another view
        for (int t = 0; t < 4; t++) begin
            kbd(t[1], t[0], 8'h12);
            chk_all("R2 trap bit", 16'h0F00, 16'(1 << (8 + t)));
            wr_reg(t % NC, 16'(1 << (8 + t)));
            chk_all("R3 w1c", 16'hFFFF, 16'h0000);
        end
        // R2 foreign address
        kbd(0, 1, 8'h00, 16'h0061);
        kbd(1, 0, 8'h00, 16'h0065);
        chk_all("R2 foreign", 16'hFFFF, 16'h0000);

        // R3 zero write, then collision
        set_traps(4'b0101);
        wr_reg(1, 16'h0000);
        chk_all("R3 zero write", 16'h0F00, 16'h0500);
        @(negedge clk);
        snp_vld = 1; snp_wr = 1; snp_addr = 16'h0060; reg_we[2] = 1;
        reg_wdata[2*W +: W] = 16'h0F00;
        @(negedge clk);
        snp_vld = 0; snp_wr = 0; snp_addr = 0; reg_we = 0; reg_wdata = 0;
        chk_all("R3 set wins", 16'h0F00, 16'h0200);
        wr_reg(0, 16'h0F00);

        // R5 read/write bits
        wr_reg(0, 16'hFFFF);
        chk("R5 rw mask", view(0), 16'h20BF);
        chk("R5 other view", view(1), 16'h0000);
        chk("R5 other view", view(2), 16'h0000);
        wr_reg(0, 16'h0000);
        chk("R5 clear back", view(0), 16'h0000);

        // R6 sweep of status pattern against enable nibble
        for (int s = 0; s < 16; s++) begin
            wr_reg(0, 16'h0F00);
            set_traps(4'(s));
            chk_all("R2 pattern", 16'h0F00, 16'(s << 8));
            for (int c = 0; c < NC; c++) begin
                for (int e = 0; e < 16; e++) begin
                    wr_reg(c, 16'(e));
                    chk("R6 smi", smi_o, ((s & e) != 0) ? (1 << c) : 0);
                end
                wr_reg(c, 16'h0000);
            end
        end
        wr_reg(0, 16'h0F00);

        // R4 usb flag
        @(negedge clk); usb_evt[1] = 1; @(negedge clk); usb_evt = 0;
        chk("R4 set own", view(1) & 16'h1000, 16'h1000);
        chk("R4 not other", (view(0) | view(2)) & 16'h1000, 0);
        chk("R4 no smi", smi_o, 0);
        wr_reg(1, 16'h0010);
        chk("R6 usb smi", smi_o, 3'b010);
        wr_reg(0, 16'h1000);
        chk("R4 foreign clear", view(1) & 16'h1000, 16'h1000);
        wr_reg(1, 16'h1000);
        chk("R4 own clear", view(1) & 16'h1000, 0);

        // R7 full sequence
        wr_reg(2, 16'h0020);
        kbd(1, 1, 8'hD1);
        chk_all("R7 active cmd", 16'h0F40, 16'h0040);
        kbd(0, 1, 8'h55);
        chk_all("R7 active data", 16'h0F40, 16'h0040);
        kbd(1, 1, 8'hFF);
        chk_all("R7 exit", 16'h8F40, 16'h8000);
        chk("R7 no smi", smi_o, 0);
        wr_reg(0, 16'h0080);
        chk("R6 ptend smi all", smi_o, 3'b111);
        wr_reg(1, 16'h8000);
        chk_all("R3 ptend clear", 16'h8000, 16'h0000);
        chk("R6 smi off", smi_o, 0);

        // R8 abort by read, restart, abort by wrong exit byte
        kbd(1, 1, 8'hD1);
        kbd(0, 0, 8'h00);
        chk_all("R8 abort", 16'h0F40, 16'h0100);
        wr_reg(0, 16'h0F00);
        kbd(1, 1, 8'hD1);
        kbd(1, 1, 8'hD1);
        chk_all("R8 restart", 16'h0F40, 16'h0040);
        kbd(0, 1, 8'h33);
        kbd(1, 1, 8'h00);
        chk_all("R8 bad exit", 16'h8F40, 16'h0800);
        wr_reg(0, 16'h0F00);

        // R9 disable forces idle, then bytes trap normally
        kbd(1, 1, 8'hD1);
        chk_all("R9 pre active", 16'h0040, 16'h0040);
        wr_reg(2, 16'h0000);
        @(negedge clk);
        chk_all("R9 forced idle", 16'h0040, 16'h0000);
        kbd(1, 1, 8'hD1);
        chk_all("R9 disabled trap", 16'h0F40, 16'h0800);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule